// File: doc/BRIEF.md
# Serial Conversion Result Shifter with Tag Pass-Through

This block is the readout half of a 12-bit converter. When the conversion engine finishes, it strobes the result into the block. The block then shifts the result out on a serial data line, paced by an externally supplied data clock. That clock is sampled by the block's own system clock and is not used as a clock inside the block.

Each frame opens with a marker pulse that lasts exactly one data clock period. The result bits follow, most significant first. After the result, the block keeps forwarding whatever bits arrive on its tag input. Wiring one device's serial output into the next device's tag input therefore builds a daisy chain, and a single receiver can read every result in the chain through one wire.

Readout takes place only while chip select is low and the read/convert control is high. Outside that window the serial output is released, and data clock activity is ignored. A result that arrives while readout is enabled and the data clock is high cannot be taken safely. Such a result is thrown away, and a data-lost flag is raised.

Top module: `adc_serial_readout`

## Requirements
- R1: After reset, `sdata`, `sync` and `data_lost` are all 0.
- R2: `sdata_oe` is 1 exactly when `cs_n` is 0 and `rd_cv` is 1. While that condition is false, data clock edges have no effect: `sdata` and `sync` keep their values, and no tag bit is captured.
- R3: After an accepted load, the first enabled rising edge of `dclk` sets `sync` to 1. The next enabled rising edge sets it back to 0, so `sync` is high for exactly one data clock period per frame.
- R4: Enabled rising edges 2 to 13 after a load put result bits 11 down to 0 on `sdata`, MSB first. Each bit is therefore stable across the following falling edge and the following rising edge. After rising edge 1, `sdata` is 0.
- R5: `tag` is sampled on every enabled falling edge of `dclk`. The bit sampled at falling edge k of a frame appears on `sdata` after rising edge k+13. Tag bits keep streaming out for as long as no new result is accepted.
- R6: A load (`ld` high) while `cs_n` is 0, `rd_cv` is 1 and `dclk` is high is discarded. In that case `data_lost` goes to 1, and the frame in progress continues unchanged.
- R7: Any other load is accepted. It clears `data_lost`, drives `sdata` and `sync` to 0, and restarts the frame. Until then, the previous result and its tag stream stay readable.
- R8: Two instances can be chained, with the upstream `sdata` gated by its `sdata_oe` feeding the downstream `tag`. The downstream line then carries its own 12 bits, one fill bit of 0, and then the upstream 12 bits, all MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the data clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_cv | input | 1 | High selects readout, low selects conversion |
| dclk | input | 1 | External data clock, slower than `clk` |
| tag | input | 1 | Serial bits forwarded after the result |
| ld | input | 1 | One-cycle strobe: new result available |
| ld_res | input | RES_W | New conversion result |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Output enable for `sdata` |
| sync | output | 1 | Frame marker, one data clock period long |
| data_lost | output | 1 | Set when a load was discarded |

## Verification
The bench builds both instances with RES_W = 12 and SYNC_STAGES = 2. With these values a full chained frame plus several forwarded tag bits fits in about thirty data clock periods, so one run covers the MSB, LSB, fill-bit and tag-stream positions. The two-stage sampler gives a fixed three-cycle latency per data clock edge. A six-cycle half period keeps every edge's effect inside its own phase, which is what makes a load during a high phase reliably reach the discard path. The downstream instance is also reloaded on its own while the upstream instance keeps streaming, so the tag path is exercised with frames that are out of step.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
   localparam int unsigned DEF_RES_W       = 12;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   typedef struct packed {
      logic lvl;
      logic rise;
      logic fall;
   } dclk_evt_t;
endpackage

// File: rtl/dclk_edge.sv
module dclk_edge #(
   parameter int unsigned STAGES = adc_ser_pkg::DEF_SYNC_STAGES
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   dclk,
   output adc_ser_pkg::dclk_evt_t evt
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 1) begin : g_bad_stages
      $error("dclk_edge: STAGES must be at least 1");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= dclk;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[STAGES-2:0], dclk};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[LAST];
   end

   always_comb begin
      evt.lvl  = sync_q[LAST];
      evt.rise = sync_q[LAST] & ~prev_q;
      evt.fall = ~sync_q[LAST] & prev_q;
   end
endmodule

// File: rtl/ld_gate.sv
module ld_gate #(
   parameter int unsigned RES_W = adc_ser_pkg::DEF_RES_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [RES_W-1:0] ld_res,
   input  logic             rd_en,
   input  logic             dclk_lvl,
   output logic             take,
   output logic [RES_W-1:0] take_res,
   output logic             lost
);
   logic unsafe;

   always_comb begin
      unsafe   = rd_en & dclk_lvl;
      take     = ld & ~unsafe;
      take_res = ld_res;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             lost <= 1'b0;
      else if (ld && unsafe)  lost <= 1'b1;
      else if (ld)            lost <= 1'b0;
   end

   // R6: a load during an enabled high phase raises the flag
   a_r6_drop_sets_lost: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && rd_en && dclk_lvl) |=> lost);
   // R7: a load outside that window clears the flag
   a_r7_accept_clears_lost: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !(rd_en && dclk_lvl)) |=> !lost);
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
   parameter int unsigned RES_W = adc_ser_pkg::DEF_RES_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [RES_W-1:0] take_res,
   input  logic             rd_en,
   input  logic             rise,
   input  logic             fall,
   input  logic             tag,
   output logic             sdata,
   output logic             sync
);
   if (RES_W < 2) begin : g_bad_width
      $error("frame_shifter: RES_W must be at least 2");
   end

   logic [RES_W-1:0] sh_q;
   logic             pend_q;
   logic             tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         pend_q <= 1'b0;
         tag_q  <= 1'b0;
         sdata  <= 1'b0;
         sync   <= 1'b0;
      end else if (take) begin
         sh_q   <= take_res;
         pend_q <= 1'b1;
         sdata  <= 1'b0;
         sync   <= 1'b0;
      end else if (rd_en) begin
         if (fall) tag_q <= tag;
         if (rise) begin
            if (pend_q) begin
               pend_q <= 1'b0;
               sync   <= 1'b1;
               sdata  <= 1'b0;
            end else begin
               sync   <= 1'b0;
               sdata  <= sh_q[RES_W-1];
               sh_q   <= {sh_q[RES_W-2:0], tag_q};
            end
         end
      end
   end

   // R2: no movement while readout is disabled
   a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && !take) |=> ($stable(sdata) && $stable(sync)));
   // R3: the marker never survives a second enabled rising edge
   a_r3_sync_one_period: assert property (@(posedge clk) disable iff (!rst_n)
      (sync && rise && rd_en && !take) |=> !sync);
   // R4: each shift presents the old top bit
   a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && rd_en && !take && !pend_q) |=> (sdata == $past(sh_q[RES_W-1])));
   // R7: an accepted load restarts the frame with quiet outputs
   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (!sync && !sdata && pend_q));
endmodule

// File: rtl/adc_serial_readout.sv
module adc_serial_readout #(
   parameter int unsigned RES_W       = adc_ser_pkg::DEF_RES_W,
   parameter int unsigned SYNC_STAGES = adc_ser_pkg::DEF_SYNC_STAGES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             rd_cv,
   input  logic             dclk,
   input  logic             tag,
   input  logic             ld,
   input  logic [RES_W-1:0] ld_res,
   output logic             sdata,
   output logic             sdata_oe,
   output logic             sync,
   output logic             data_lost
);
   adc_ser_pkg::dclk_evt_t evt;
   logic                   rd_en;
   logic                   take;
   logic [RES_W-1:0]       take_res;

   assign rd_en    = ~cs_n & rd_cv;
   assign sdata_oe = rd_en;

   dclk_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .dclk  (dclk),
      .evt   (evt)
   );

   ld_gate #(.RES_W(RES_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ld),
      .ld_res   (ld_res),
      .rd_en    (rd_en),
      .dclk_lvl (evt.lvl),
      .take     (take),
      .take_res (take_res),
      .lost     (data_lost)
   );

   frame_shifter #(.RES_W(RES_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .take_res (take_res),
      .rd_en    (rd_en),
      .rise     (evt.rise),
      .fall     (evt.fall),
      .tag      (tag),
      .sdata    (sdata),
      .sync     (sync)
   );

   // R1: quiet outputs straight after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      $rose(rst_n) |-> (!sdata && !sync && !data_lost));
endmodule

// File: tb/tb_adc_serial_readout.sv
module tb_adc_serial_readout;
   localparam int W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, rd_cv = 1'b0, dclk = 1'b0;
   logic a_tag = 1'b0;
   logic ld_a = 1'b0, ld_b = 1'b0;
   logic [W-1:0] res_a = '0, res_b = '0;
   logic a_sd, a_oe, a_sy, a_lost;
   logic sdata, sdata_oe, sync, data_lost;
   logic b_tag;

   always #10 clk = ~clk;

   assign b_tag = a_sd & a_oe;

   adc_serial_readout #(.RES_W(W), .SYNC_STAGES(2)) up (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cv(rd_cv), .dclk(dclk),
      .tag(a_tag), .ld(ld_a), .ld_res(res_a),
      .sdata(a_sd), .sdata_oe(a_oe), .sync(a_sy), .data_lost(a_lost));

   adc_serial_readout #(.RES_W(W), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cv(rd_cv), .dclk(dclk),
      .tag(b_tag), .ld(ld_b), .ld_res(res_b),
      .sdata(sdata), .sdata_oe(sdata_oe), .sync(sync), .data_lost(data_lost));

   int checks = 0, errors = 0;
   bit exp_sd[$];
   bit exp_sy[$];
   string exp_rq[$];
   event smp;

   int g = 0, a_idx = 0, b_idx = 0;
   bit hist_a[0:255];
   logic [W-1:0] ra, rb;

   task automatic chk(bit ok, string rq, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic bit atag(int k);
      return bit'((k % 3 == 0) ^ (k % 5 == 1));
   endfunction

   // monitor: pops the next expected item for each sampled edge
   always @(smp) begin
      if (exp_sd.size() == 0) begin
         chk(1'b0, "queue", 0, 1);
      end else begin
         bit e_sd, e_sy;
         string rq;
         e_sd = exp_sd.pop_front();
         e_sy = exp_sy.pop_front();
         rq = exp_rq.pop_front();
         chk(sdata === e_sd, rq, int'(sdata), int'(e_sd));
         chk(sync === e_sy, "R3", int'(sync), int'(e_sy));
      end
   end

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: one enabled data clock period plus expected push
   task automatic edge_on();
      bit av, bv;
      string rq;
      a_tag = atag(g + 1);
      dclk = 1'b1; wait_clk(6);
      dclk = 1'b0; wait_clk(6);
      g++; a_idx++; b_idx++;
      if (a_idx == 1) av = 1'b0;
      else if (a_idx <= W + 1) av = ra[W + 1 - a_idx];
      else av = atag(g - 13);
      hist_a[g] = av;
      if (b_idx == 1) begin bv = 1'b0; rq = "R4"; end
      else if (b_idx <= W + 1) begin bv = rb[W + 1 - b_idx]; rq = "R4"; end
      else begin
         bv = hist_a[g - 13];
         rq = (b_idx <= 2 * W + 2) ? "R8" : "R5";
      end
      exp_sd.push_back(bv);
      exp_sy.push_back(b_idx == 1);
      exp_rq.push_back(rq);
      -> smp;
      #1;
   endtask

   task automatic load_b(logic [W-1:0] v);
      res_b = v; ld_b = 1'b1; wait_clk(1); ld_b = 1'b0; wait_clk(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit sd0, sy0;
      wait_clk(3);
      // R1: reset state
      chk(sdata === 1'b0, "R1", int'(sdata), 0);
      chk(sync === 1'b0, "R1", int'(sync), 0);
      chk(data_lost === 1'b0, "R1", int'(data_lost), 0);
      rst_n = 1'b1; wait_clk(3);
      chk(sdata_oe === 1'b0, "R2", int'(sdata_oe), 0);
      cs_n = 1'b0; wait_clk(1);
      chk(sdata_oe === 1'b0, "R2", int'(sdata_oe), 0);
      rd_cv = 1'b1; wait_clk(1);
      chk(sdata_oe === 1'b1, "R2", int'(sdata_oe), 1);

      // load both while the data clock is low: accepted (R7)
      ra = 12'hA5C; rb = 12'h3E1;
      res_a = ra; res_b = rb; ld_a = 1'b1; ld_b = 1'b1; wait_clk(1);
      ld_a = 1'b0; ld_b = 1'b0; wait_clk(2);
      a_idx = 0; b_idx = 0;
      chk(data_lost === 1'b0, "R7", int'(data_lost), 0);
      // chained frame, fill bit, upstream frame, then tag stream (R4 R5 R8)
      for (int i = 0; i < 30; i++) edge_on();

      // R2: disabled pulses are ignored
      cs_n = 1'b1; wait_clk(1);
      chk(sdata_oe === 1'b0, "R2", int'(sdata_oe), 0);
      sd0 = sdata; sy0 = sync;
      for (int i = 0; i < 3; i++) begin
         a_tag = ~a_tag;
         dclk = 1'b1; wait_clk(6); dclk = 1'b0; wait_clk(6);
         chk(sdata === sd0, "R2", int'(sdata), int'(sd0));
         chk(sync === sy0, "R2", int'(sync), int'(sy0));
      end
      cs_n = 1'b0; wait_clk(1);
      for (int i = 0; i < 4; i++) edge_on();

      // R6: load while enabled and dclk high is discarded
      a_tag = atag(g + 1);
      dclk = 1'b1; wait_clk(6);
      res_b = 12'h0F0; ld_b = 1'b1; wait_clk(1); ld_b = 1'b0; wait_clk(2);
      chk(data_lost === 1'b1, "R6", int'(data_lost), 1);
      dclk = 1'b0; wait_clk(6);
      begin
         bit bv;
         g++; a_idx++; b_idx++;
         hist_a[g] = atag(g - 13);
         bv = hist_a[g - 13];
         exp_sd.push_back(bv); exp_sy.push_back(1'b0); exp_rq.push_back("R6");
         -> smp; #1;
      end
      for (int i = 0; i < 2; i++) edge_on();

      // R6: same load with readout disabled is accepted
      rd_cv = 1'b0; dclk = 1'b1; wait_clk(6);
      rb = 12'h5A7; load_b(rb);
      chk(data_lost === 1'b0, "R6", int'(data_lost), 0);
      dclk = 1'b0; wait_clk(6);
      rd_cv = 1'b1; wait_clk(1);
      b_idx = 0;
      // R7: restarted downstream frame while upstream keeps streaming
      for (int i = 0; i < 16; i++) edge_on();

      // R7: reload while enabled with dclk low
      rb = 12'h801; load_b(rb);
      chk(sync === 1'b0, "R7", int'(sync), 0);
      chk(sdata === 1'b0, "R7", int'(sdata), 0);
      b_idx = 0;
      for (int i = 0; i < 14; i++) edge_on();

      wait_clk(4);
      chk(exp_sd.size() == 0, "queue", exp_sd.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule